// File: doc/BRIEF.md
# I2C Register-Port Slave with Pointer Autoincrement

This block is a byte-wide register file of 2^AW entries that an I2C master reaches over a two-wire bus. The master addresses the slave at the fixed 7-bit address 1001010. In a write transaction the first byte after the address is a pointer byte. Bit 7 of that byte is an autoincrement flag, and bits 6:0 select a register. Any further bytes in the same write are stored in the register file. A read transaction sends out register contents starting at the current pointer.

The bus pins are open-drain. The block reads SCL and SDA as inputs and pulls SDA low through a single enable output. Both lines are resynchronised to the system clock and oversampled, so the system clock must run at least 8 times faster than SCL. A master can set the read address by writing only the pointer byte and then sending a stop. The pointer keeps that value, and a following read starts there. If autoincrement is set, each byte transferred moves the pointer to the next address, and the pointer wraps from the top of the file to 0. If autoincrement is clear, the pointer does not move.

Top module: `i2c_regport`

## Requirements
- R1: The slave acknowledges address byte 0x94 (write) and 0x95 (read). For any other address it drives no acknowledge and leaves SDA released until the next start condition, including while further bytes are clocked.
- R2: In a write, the byte after the address is acknowledged. Its bits 6:0 load the pointer and its bit 7 sets the autoincrement mode (1 = advance).
- R3: A write ended by a stop right after the pointer byte changes no register, and the next read returns the register at the new pointer.
- R4: Read data is shifted out most significant bit first, one bit per SCL period.
- R5: With autoincrement set, successive bytes of one read come from consecutive addresses, wrapping from 0x7F to 0x00.
- R6: With autoincrement clear, every byte read returns the selected register and the pointer stays unchanged across transactions.
- R7: Data bytes after the pointer byte are stored at the pointer and acknowledged. With autoincrement set they go to consecutive addresses (wrapping modulo 128). With it clear they all go to the same register, and the last byte written is kept.
- R8: After the master does not acknowledge a read byte, the slave releases SDA and drives nothing more until a start.
- R9: A repeated start in the middle of a byte restarts address reception. It leaves the pointer and all registers unchanged.
- R10: After reset SDA is released, all registers hold 0x00, and the pointer is 0 with autoincrement clear.
- R11: The slave begins pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 = pull SDA low |

## Verification
Two pointer-handling actions can fall on the same system clock edge. In a write, the register write and the pointer step happen together, so the write must use the old pointer value. In a read, the pointer step on the master-acknowledge edge must be complete before the next byte is fetched. Both cases are provoked by autoincrement transfers that start at 0x7E and cross the wrap to 0x00. The results are judged by reading each address back and comparing it with the byte that was written there. A pointer that is early or late by one address shows up as a shifted value.

// File: rtl/i2c_regport_pkg.sv
// Package: shared types for the I2C register-port slave.
// Assumes: one byte per bus transfer; state encoding is free for synthesis.
package i2c_regport_pkg;

    localparam int BYTE_W = 8;

    // Protocol phase of the slave controller
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ADDR   = 3'd1,
        ST_MAP    = 3'd2,
        ST_WDATA  = 3'd3,
        ST_ACK    = 3'd4,
        ST_RDATA  = 3'd5,
        ST_RACK   = 3'd6,
        ST_IGNORE = 3'd7
    } st_t;

endpackage

// File: rtl/i2c_regport_sync.sv
// Module: resynchronises SCL/SDA and detects edges, start and stop.
// Assumes: lines idle high; clk is at least 8x the SCL rate so every
// bus level is seen for several clk cycles.
module i2c_regport_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] scl_pipe;
    logic [CHAIN-1:0] sda_pipe;

    // Synchroniser chain plus one history stage per line
    genvar g;
    generate
        for (g = 0; g < CHAIN; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        scl_pipe[g] <= 1'b1;
                        sda_pipe[g] <= 1'b1;
                    end else begin
                        scl_pipe[g] <= scl_i;
                        sda_pipe[g] <= sda_i;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        scl_pipe[g] <= 1'b1;
                        sda_pipe[g] <= 1'b1;
                    end else begin
                        scl_pipe[g] <= scl_pipe[g-1];
                        sda_pipe[g] <= sda_pipe[g-1];
                    end
                end
            end
        end
    endgenerate

    logic scl_prev, sda_prev;

    // Event decode from the synchronised level and its previous value
    always_comb begin
        scl_s     = scl_pipe[STAGES-1];
        sda_s     = sda_pipe[STAGES-1];
        scl_prev  = scl_pipe[STAGES];
        sda_prev  = sda_pipe[STAGES];
        scl_rise  = scl_s & ~scl_prev;
        scl_fall  = ~scl_s & scl_prev;
        start_det = scl_s & scl_prev & sda_prev & ~sda_s;
        stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
    end

endmodule

// File: rtl/i2c_regport_regs.sv
// Module: register file, one synchronous write port, one combinational read.
// Assumes: write and read address may be equal; read sees the old value.
module i2c_regport_regs #(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_reg
            // One storage word, cleared on reset, loaded on address match
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mem[g] <= '0;
                else if (we && (waddr == AW'(g)))
                    mem[g] <= wdata;
            end
        end
    endgenerate

    // Read mux at the pointer
    always_comb rdata = mem[raddr];

endmodule

// File: rtl/i2c_regport_ctrl.sv
// Module: I2C slave protocol engine and register pointer.
// Assumes: inputs come from i2c_regport_sync; SDA changes are made only
// after a synchronised SCL fall; a start or stop overrides any phase.
module i2c_regport_ctrl
    import i2c_regport_pkg::*;
#(
    parameter int           AW         = 7,
    parameter logic [6:0]   SLAVE_ADDR = 7'b1001010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              we,
    output logic [AW-1:0]     waddr,
    output logic [BYTE_W-1:0] wdata,
    output logic [AW-1:0]     ptr,
    output logic              ainc,
    output logic              sda_oe,
    output st_t               st
);
    localparam int FLAG_BIT = BYTE_W - 1;
    localparam int CNT_W    = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(BYTE_W);

    st_t               ack_next;
    logic              ack_ph;
    logic              mack;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txreg;
    logic [BYTE_W-1:0] rx_byte;
    logic              byte_done;

    // Byte being completed on this SCL rise and the register write strobe
    always_comb begin
        rx_byte   = {shreg[BYTE_W-2:0], sda_s};
        byte_done = scl_rise && (bitcnt == LAST_BIT);
        we        = (st == ST_WDATA) && byte_done;
        waddr     = ptr;
        wdata     = rx_byte;
    end

    // Protocol sequencing, pointer handling and SDA drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            ack_next <= ST_IDLE;
            ack_ph   <= 1'b0;
            mack     <= 1'b0;
            bitcnt   <= '0;
            shreg    <= '0;
            txreg    <= '0;
            ptr      <= '0;
            ainc     <= 1'b0;
            sda_oe   <= 1'b0;
        end else if (start_det) begin
            st     <= ST_ADDR;
            bitcnt <= '0;
            ack_ph <= 1'b0;
            sda_oe <= 1'b0;
        end else if (stop_det) begin
            st     <= ST_IDLE;
            bitcnt <= '0;
            ack_ph <= 1'b0;
            sda_oe <= 1'b0;
        end else begin
            case (st)
                ST_ADDR, ST_MAP, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg  <= rx_byte;
                        bitcnt <= bitcnt + 1'b1;
                    end
                    if (byte_done) begin
                        bitcnt <= '0;
                        if (st == ST_ADDR) begin
                            if (rx_byte[BYTE_W-1:1] == SLAVE_ADDR) begin
                                st       <= ST_ACK;
                                ack_next <= rx_byte[0] ? ST_RDATA : ST_MAP;
                            end else begin
                                st <= ST_IGNORE;
                            end
                        end else if (st == ST_MAP) begin
                            ptr      <= rx_byte[AW-1:0];
                            ainc     <= rx_byte[FLAG_BIT];
                            st       <= ST_ACK;
                            ack_next <= ST_WDATA;
                        end else begin
                            if (ainc)
                                ptr <= ptr + 1'b1;
                            st       <= ST_ACK;
                            ack_next <= ST_WDATA;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (!ack_ph) begin
                            sda_oe <= 1'b1;
                            ack_ph <= 1'b1;
                        end else begin
                            ack_ph <= 1'b0;
                            st     <= ack_next;
                            if (ack_next == ST_RDATA) begin
                                txreg  <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_rise)
                        bitcnt <= bitcnt + 1'b1;
                    if (scl_fall) begin
                        if (bitcnt == ALL_BITS) begin
                            bitcnt <= '0;
                            sda_oe <= 1'b0;
                            st     <= ST_RACK;
                        end else begin
                            txreg  <= {txreg[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~txreg[BYTE_W-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_s;
                        if (ainc)
                            ptr <= ptr + 1'b1;
                    end
                    if (scl_fall) begin
                        if (mack) begin
                            st     <= ST_RDATA;
                            txreg  <= rd_data;
                            sda_oe <= ~rd_data[BYTE_W-1];
                        end else begin
                            st <= ST_IGNORE;
                        end
                    end
                end
                default: begin
                    sda_oe <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/i2c_regport.sv
// Module: top of the I2C register-port slave.
// Assumes: open-drain bus, SDA pulled low when sda_oe is 1; clk at
// least 8x SCL; no clock stretching.
module i2c_regport
    import i2c_regport_pkg::*;
#(
    parameter int         AW          = 7,
    parameter logic [6:0] SLAVE_ADDR  = 7'b1001010,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              reg_we;
    logic [AW-1:0]     reg_waddr;
    logic [BYTE_W-1:0] reg_wdata;
    logic [BYTE_W-1:0] reg_rdata;
    logic [AW-1:0]     ptr;
    logic              ainc;
    st_t               st;

    i2c_regport_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_regport_ctrl #(.AW(AW), .SLAVE_ADDR(SLAVE_ADDR)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (reg_rdata),
        .we        (reg_we),
        .waddr     (reg_waddr),
        .wdata     (reg_wdata),
        .ptr       (ptr),
        .ainc      (ainc),
        .sda_oe    (sda_oe),
        .st        (st)
    );

    i2c_regport_regs #(.AW(AW), .DW(BYTE_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .waddr (reg_waddr),
        .wdata (reg_wdata),
        .raddr (ptr),
        .rdata (reg_rdata)
    );

endmodule

// File: rtl/i2c_regport_checker.sv
// Module: protocol assertions for i2c_regport, attached by bind.
// Assumes: observes ports plus the pointer and write strobe between
// the controller and the register file.
module i2c_regport_checker
    import i2c_regport_pkg::*;
#(
    parameter int AW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_i,
    input logic          sda_oe,
    input logic          we,
    input logic [AW-1:0] ptr,
    input logic          ainc,
    input st_t           st
);
    // SDA is first pulled low only in the SCL low phase
    assert_oe_rise_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    // Leaving reset finds SDA released
    assert_reset_released_R10: assert property (@(posedge clk)
        $rose(rst_n) |-> !sda_oe);

    // Autoincrement write steps the pointer by one, modulo the file size
    assert_wr_ptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && ainc) |=> (ptr == AW'($past(ptr) + 1'b1)));

    // Write without autoincrement keeps the pointer
    assert_wr_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !ainc) |=> (ptr == $past(ptr)));

    // SDA is driven only for an acknowledge or read data
    assert_drive_addressed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (st == ST_ACK || st == ST_RDATA));

    // After a master not-acknowledge the slave stays off the bus
    assert_quiet_after_nack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IGNORE) |-> !sda_oe);

endmodule

bind i2c_regport i2c_regport_checker #(.AW(AW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl_i),
    .sda_oe (sda_oe),
    .we     (reg_we),
    .ptr    (ptr),
    .ainc   (ainc),
    .st     (st)
);

// File: tb/i2c_regport_bench.sv
// Directed bench: an I2C master model drives the bus, one task per scenario.
module i2c_regport_bench;
    localparam int Q = 4;  // clk cycles per quarter SCL period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda_low = 1'b0;
    logic sda_oe;
    logic sda_bus;
    int   n_chk = 0;
    int   n_err = 0;
    int   oe_viol = 0;
    logic oe_q = 1'b0;

    always #10 clk = ~clk;
    assign sda_bus = ~(m_sda_low | sda_oe);

    i2c_regport u_i2c_regport (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (m_scl),
        .sda_i  (sda_bus),
        .sda_oe (sda_oe)
    );

    // Port-level monitor for R11: count SDA pull-downs that begin with SCL high
    always @(negedge clk) begin
        if (rst_n && sda_oe && !oe_q && m_scl)
            oe_viol++;
        oe_q <= sda_oe;
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        wq(Q); m_sda_low = 1'b0;
        wq(Q); m_scl = 1'b1;
        wq(Q); m_sda_low = 1'b1;
        wq(Q); m_scl = 1'b0;
    endtask

    task automatic i2c_stop();
        wq(Q); m_sda_low = 1'b1;
        wq(Q); m_scl = 1'b1;
        wq(Q); m_sda_low = 1'b0;
        wq(2*Q);
    endtask

    task automatic send_bit(input logic b);
        wq(Q); m_sda_low = ~b;
        wq(Q); m_scl = 1'b1;
        wq(2*Q); m_scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        wq(Q); m_sda_low = 1'b0;
        wq(Q); m_scl = 1'b1;
        wq(Q); ack = ~sda_bus;
        wq(Q); m_scl = 1'b0;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            wq(Q); m_sda_low = 1'b0;
            wq(Q); m_scl = 1'b1;
            wq(Q); b[i] = sda_bus;
            wq(Q); m_scl = 1'b0;
        end
        wq(Q); m_sda_low = give_ack;
        wq(Q); m_scl = 1'b1;
        wq(2*Q); m_scl = 1'b0;
        wq(Q); m_sda_low = 1'b0;
    endtask

    // Write transaction: pointer byte then n data bytes, every ack checked
    task automatic wr_txn(input logic [7:0] map, input int n,
                          input logic [7:0] d0, d1, d2, input string req);
        logic ack;
        logic [7:0] d [3];
        d[0] = d0; d[1] = d1; d[2] = d2;
        i2c_start();
        send_byte(8'h94, ack); chk({req, " addr ack"}, {7'd0, ack}, 8'd1);
        send_byte(map, ack);   chk({req, " map ack"},  {7'd0, ack}, 8'd1);
        for (int i = 0; i < n; i++) begin
            send_byte(d[i], ack); chk({req, " data ack"}, {7'd0, ack}, 8'd1);
        end
        i2c_stop();
    endtask

    // Read transaction of n bytes, last one not acknowledged
    task automatic rd_txn(input int n, input logic [7:0] e0, e1, e2, input string req);
        logic ack;
        logic [7:0] b;
        logic [7:0] e [3];
        e[0] = e0; e[1] = e1; e[2] = e2;
        i2c_start();
        send_byte(8'h95, ack); chk({req, " rd addr ack"}, {7'd0, ack}, 8'd1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            chk({req, " rd data"}, b, e[i]);
        end
        i2c_stop();
    endtask

    task automatic t_reset();
        chk("R10 sda released", {7'd0, sda_oe}, 8'd0);
        rd_txn(2, 8'h00, 8'h00, 8'h00, "R10");
    endtask

    task automatic t_write_inc();
        wr_txn(8'h85, 3, 8'hA1, 8'h3C, 8'hD2, "R7 R2");
    endtask

    task automatic t_abort_preamble();
        wr_txn(8'h06, 0, 8'h00, 8'h00, 8'h00, "R3 preamble");
        rd_txn(1, 8'h3C, 8'h00, 8'h00, "R3");
        rd_txn(2, 8'h3C, 8'h3C, 8'h00, "R6");
        wr_txn(8'h85, 0, 8'h00, 8'h00, 8'h00, "R5 preamble");
        rd_txn(3, 8'hA1, 8'h3C, 8'hD2, "R5 R4");
    endtask

    task automatic t_wrap();
        wr_txn(8'hFE, 3, 8'h11, 8'h22, 8'h33, "R7 wrap");
        wr_txn(8'hFE, 0, 8'h00, 8'h00, 8'h00, "R5 wrap preamble");
        rd_txn(3, 8'h11, 8'h22, 8'h33, "R5 wrap");
    endtask

    task automatic t_no_inc_write();
        wr_txn(8'h10, 2, 8'h55, 8'h66, 8'h00, "R7 no-inc");
        wr_txn(8'h90, 0, 8'h00, 8'h00, 8'h00, "R7 preamble");
        rd_txn(2, 8'h66, 8'h00, 8'h00, "R7 no-inc");
    endtask

    task automatic t_wrong_addr();
        logic ack;
        i2c_start();
        send_byte(8'h96, ack); chk("R1 foreign addr nack", {7'd0, ack}, 8'd0);
        send_byte(8'h05, ack); chk("R1 ignored byte nack", {7'd0, ack}, 8'd0);
        send_byte(8'h77, ack); chk("R1 ignored byte nack", {7'd0, ack}, 8'd0);
        i2c_stop();
        wr_txn(8'h05, 0, 8'h00, 8'h00, 8'h00, "R1 preamble");
        rd_txn(1, 8'hA1, 8'h00, 8'h00, "R1 reg untouched");
    endtask

    task automatic t_restart();
        logic ack;
        wr_txn(8'h0A, 1, 8'h5C, 8'h00, 8'h00, "R9 setup");
        i2c_start();
        send_byte(8'h94, ack); chk("R9 addr ack", {7'd0, ack}, 8'd1);
        send_byte(8'h0A, ack); chk("R9 map ack", {7'd0, ack}, 8'd1);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        rd_txn(1, 8'h5C, 8'h00, 8'h00, "R9");
    endtask

    task automatic t_nack_release();
        logic ack;
        logic [7:0] b;
        wr_txn(8'h05, 0, 8'h00, 8'h00, 8'h00, "R8 preamble");
        i2c_start();
        send_byte(8'h95, ack); chk("R8 rd addr ack", {7'd0, ack}, 8'd1);
        recv_byte(1'b0, b);    chk("R8 rd data", b, 8'hA1);
        chk("R8 released after nack", {7'd0, sda_oe}, 8'd0);
        recv_byte(1'b0, b);    chk("R8 bus idle after nack", b, 8'hFF);
        i2c_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        wq(5);
        rst_n = 1'b1;
        wq(5);
        t_reset();
        t_write_inc();
        t_abort_preamble();
        t_wrap();
        t_no_inc_write();
        t_wrong_addr();
        t_restart();
        t_nack_release();
        chk("R11 oe rise with scl high", oe_viol[7:0], 8'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

endmodule